// File: doc/BRIEF.md
# Double-Buffered Bulk-OUT Endpoint Status

This block keeps the status and interrupt state for two bulk-OUT endpoints, each backed by a ping-pong pair of packet buffers. One buffer faces the CPU and the other faces the receive engine. Each buffer is modelled only as a valid flag and a byte count. Receive events come in as single-cycle strobes: a good packet with its length, a zero-length packet, and an OUT token. The CPU side uses a byte-read strobe and a buffer-release strobe, both steered by an endpoint select.

The block reports an 8-bit status word. Each endpoint has a both-buffers-full flag, a null-packet flag and a NAK flag, plus a live indicator that its CPU buffer holds a packet. Software removes flags by writing zeros through a clear port. A one-cycle interrupt pulse marks every cycle in which the status word takes a new value. Any zero-length packet that arrives behind unread CPU data is held back. Its flag appears only once that data is consumed.

Top module: `bulkout_status`

## Requirements
- R1: After reset, status is 8'h00, irq is 0 and cpu_cnt is 0.
- R2: The status layout is status[7:4] for endpoint 1 and status[3:0] for endpoint 0. Within each nibble, bit 3 is FULL, bit 2 is NULL, bit 1 is NAK and bit 0 is DATA. A packet that reaches an empty CPU buffer sets DATA and loads its length into that buffer. A packet that arrives while the CPU buffer is valid goes to the receive buffer and sets FULL. Status changes on the clock edge that samples the event.
- R3: A byte read on the selected endpoint lowers its cpu_cnt by one. A read at count 0 leaves the count unchanged.
- R4: Suppose the receive buffer is full when the CPU releases its buffer. The buffers then swap: cpu_cnt takes the receive-side length, and FULL clears. A release with an empty receive buffer empties the CPU buffer and clears DATA.
- R5: A zero-length packet sets NULL at the next edge when the CPU buffer is empty or has count 0.
- R6: Suppose a zero-length packet arrives while the CPU buffer holds unread bytes. NULL then stays 0 until the read of the last byte or a release of that buffer, and is set at that edge.
- R7: An OUT token, a packet or a zero-length packet that arrives while both buffers are full sets NAK. A packet refused this way is not stored.
- R8: A clear write removes the FULL, NULL and NAK flags at every zero bit of clr_data. Ones in clr_data and the DATA bits are left unchanged.
- R9: When a flag's set event and a clear of that flag fall in the same cycle, the flag ends up set.
- R10: irq is 1 in exactly those cycles where status differs from its value in the previous cycle.
- R11: While ep_en for an endpoint is 0, that endpoint's nibble and buffer counts are held at 0 and its events are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_en | input | 2 | Per-endpoint enable |
| rx_pkt | input | 2 | Good non-empty packet received, per endpoint |
| rx_zlp | input | 2 | Zero-length packet received, per endpoint |
| rx_tok | input | 2 | OUT token seen, per endpoint |
| rx_len | input | CW | Byte length of the packet flagged on rx_pkt |
| cpu_ep | input | 1 | Endpoint addressed by the CPU strobes and cpu_cnt |
| cpu_rd | input | 1 | CPU reads one byte from the selected CPU buffer |
| cpu_rel | input | 1 | CPU releases the selected CPU buffer |
| clr_we | input | 1 | Clear write strobe |
| clr_data | input | 8 | Clear pattern, zero bits clear flags |
| status | output | 8 | Status word |
| irq | output | 1 | Pulse on any status change |
| cpu_cnt | output | CW | Bytes left in the selected CPU buffer |

## Verification
A hardware event that sets a flag and a software write that clears the same flag can fall in the same cycle. The bench provokes this by issuing an OUT token to a full endpoint, and later a packet into a half-full endpoint, in the very cycle that a clear pattern of all zeros is written. The outcome is judged on the status word at the next edge. The targeted flag must read 1, while the other flags hit by the same write must read 0.

// File: rtl/bulkout_status.sv
module bulkout_status #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ep_en,
  input  logic [1:0]    rx_pkt,
  input  logic [1:0]    rx_zlp,
  input  logic [1:0]    rx_tok,
  input  logic [CW-1:0] rx_len,
  input  logic          cpu_ep,
  input  logic          cpu_rd,
  input  logic          cpu_rel,
  input  logic          clr_we,
  input  logic [7:0]    clr_data,
  output logic [7:0]    status,
  output logic          irq,
  output logic [CW-1:0] cpu_cnt
);
  localparam int NE = 2;

  logic [7:0]    stat_q, stat_n;
  logic [CW-1:0] cnt_all [NE];

  for (genvar e = 0; e < NE; e++) begin : g_ep
    logic          cv, rv, fl, nl, nk, pd;
    logic [CW-1:0] cc, rc;
    logic          n_cv, n_rv, n_fl, n_nl, n_nk, n_pd;
    logic [CW-1:0] n_cc, n_rc;
    logic          sel, fin, swap, s_fl, s_nl, s_nk;

    assign sel = (cpu_ep == 1'(e));

    always_comb begin
      n_cv = cv; n_rv = rv; n_cc = cc; n_rc = rc; n_pd = pd;
      fin = 1'b0; swap = 1'b0; s_fl = 1'b0; s_nl = 1'b0; s_nk = 1'b0;
      if (cpu_rd && sel && cv && cc != '0) begin
        n_cc = cc - 1'b1;
        fin  = (cc == CW'(1));
      end
      if (cpu_rel && sel && cv) begin
        fin = 1'b1;
        if (rv) begin
          n_cc = rc; n_rv = 1'b0; n_rc = '0; swap = 1'b1;
        end else begin
          n_cv = 1'b0; n_cc = '0;
        end
      end
      if (pd && fin) begin
        s_nl = 1'b1; n_pd = 1'b0;
      end
      if (rx_pkt[e]) begin
        if (!n_cv) begin
          n_cv = 1'b1; n_cc = rx_len;
        end else if (!n_rv) begin
          n_rv = 1'b1; n_rc = rx_len; s_fl = 1'b1;
        end else s_nk = 1'b1;
      end
      if (rx_tok[e] && n_cv && n_rv) s_nk = 1'b1;
      if (rx_zlp[e]) begin
        if (n_cv && n_rv) s_nk = 1'b1;
        else if (n_cv && n_cc != '0) n_pd = 1'b1;
        else s_nl = 1'b1;
      end
      n_fl = (fl && !swap && !(clr_we && !clr_data[4*e+3])) || s_fl;
      n_nl = (nl && !(clr_we && !clr_data[4*e+2])) || s_nl;
      n_nk = (nk && !(clr_we && !clr_data[4*e+1])) || s_nk;
      if (!ep_en[e]) begin
        n_cv = 1'b0; n_rv = 1'b0; n_cc = '0; n_rc = '0; n_pd = 1'b0;
        n_fl = 1'b0; n_nl = 1'b0; n_nk = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cv <= 1'b0; rv <= 1'b0; cc <= '0; rc <= '0; pd <= 1'b0;
        fl <= 1'b0; nl <= 1'b0; nk <= 1'b0;
      end else begin
        cv <= n_cv; rv <= n_rv; cc <= n_cc; rc <= n_rc; pd <= n_pd;
        fl <= n_fl; nl <= n_nl; nk <= n_nk;
      end
    end

    assign stat_q[4*e +: 4] = {fl, nl, nk, cv};
    assign stat_n[4*e +: 4] = {n_fl, n_nl, n_nk, n_cv};
    assign cnt_all[e] = cc;

    a_r7_nak_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (ep_en[e] && rx_tok[e] && cv && rv && !(cpu_rel && sel)) |=> nk);
    a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ep_en[e] && rx_pkt[e] && cv && !rv && !(cpu_rel && sel) && clr_we && !clr_data[4*e+3]) |=> fl);
    a_r4_swap_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
      (ep_en[e] && fl && cpu_rel && sel && !rx_pkt[e]) |=> !status[4*e+3]);
    a_r6_pending_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ep_en[e] && pd && !(sel && (cpu_rd || cpu_rel))) |=> pd);
    a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ep_en[e] |=> (status[4*e +: 4] == 4'h0 && cnt_all[e] == '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= (stat_n != stat_q);
  end

  assign status  = stat_q;
  assign cpu_cnt = cnt_all[cpu_ep];

  a_r10_irq_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (status != $past(status)) |-> irq);
  a_r10_irq_only_change: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != $past(status)));
endmodule

// File: tb/bulkout_status_test.sv
module bulkout_status_test;
  localparam int CW = 7;
  logic clk = 0, rst_n = 0;
  logic [1:0] ep_en = 2'b11, rx_pkt = 0, rx_zlp = 0, rx_tok = 0;
  logic [CW-1:0] rx_len = 0;
  logic cpu_ep = 0, cpu_rd = 0, cpu_rel = 0, clr_we = 0;
  logic [7:0] clr_data = 0, status;
  logic irq;
  logic [CW-1:0] cpu_cnt;
  int tests = 0, fails = 0;
  logic [7:0] prev = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bulkout_status #(.CW(CW)) uut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    chk("R10 irq", int'(irq), int'(status != prev));
    prev = status;
    rx_pkt = 0; rx_zlp = 0; rx_tok = 0; cpu_rd = 0; cpu_rel = 0; clr_we = 0;
  endtask

  function automatic int nib(input int e);
    return int'(status[4*e +: 4]);
  endfunction

  task automatic pkt(input int e, input int len);
    rx_pkt[e] = 1; rx_len = CW'(len); tick();
  endtask
  task automatic zlp(input int e); rx_zlp[e] = 1; tick(); endtask
  task automatic tok(input int e); rx_tok[e] = 1; tick(); endtask
  task automatic rd(input int e);  cpu_ep = e[0]; cpu_rd = 1; tick(); endtask
  task automatic rel(input int e); cpu_ep = e[0]; cpu_rel = 1; tick(); endtask
  task automatic clr(input int m); clr_we = 1; clr_data = 8'(m); tick(); endtask
  task automatic wipe();
    ep_en = 0; tick(); ep_en = 2'b11;
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    chk("R1 status", int'(status), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 cnt", int'(cpu_cnt), 0);

    for (int e = 0; e < 2; e++) begin
      for (int len = 1; len <= 21; len++) begin
        int l;
        l = (len == 21) ? 127 : len;
        cpu_ep = e[0];
        pkt(e, l);
        chk("R2 data bit", nib(e), 1);
        chk("R2 cnt", int'(cpu_cnt), l);
        for (int k = 1; k <= l; k++) begin
          rd(e);
          chk("R3 cnt", int'(cpu_cnt), l - k);
        end
        rd(e);
        chk("R3 read at zero", int'(cpu_cnt), 0);
        chk("R5 no null after drain", nib(e), 1);
        rel(e);
        chk("R4 empty release", nib(e), 0);
      end
    end

    cpu_ep = 0;
    pkt(0, 4);
    pkt(0, 6);
    chk("R2 full", nib(0), 4'b1001);
    chk("R2 cnt kept", int'(cpu_cnt), 4);
    rel(0);
    chk("R4 swap flags", nib(0), 4'b0001);
    chk("R4 swap cnt", int'(cpu_cnt), 6);
    rel(0);
    chk("R4 emptied", nib(0), 0);

    pkt(0, 3); pkt(0, 5); tok(0);
    chk("R7 token nak", nib(0), 4'b1011);
    clr(8'hFD);
    pkt(0, 9);
    chk("R7 packet nak", nib(0), 4'b1011);
    clr(8'hFD);
    zlp(0);
    chk("R7 zlp nak", nib(0), 4'b1011);
    rel(0);
    chk("R7 swap cnt", int'(cpu_cnt), 5);
    chk("R7 swap flags", nib(0), 4'b0011);
    rel(0);
    chk("R7 refused not stored", nib(0), 4'b0010);
    chk("R7 refused cnt", int'(cpu_cnt), 0);
    clr(8'hFD);
    chk("R8 nak cleared", nib(0), 0);

    zlp(1);
    chk("R5 null empty", nib(1), 4'b0100);
    clr(8'hBF);
    chk("R8 null cleared", nib(1), 0);

    cpu_ep = 1;
    pkt(1, 2);
    zlp(1);
    chk("R6 held back", nib(1), 4'b0001);
    rd(1);
    chk("R6 still held", nib(1), 4'b0001);
    rd(1);
    chk("R6 set at last byte", nib(1), 4'b0101);
    rel(1);
    chk("R6 after release", nib(1), 4'b0100);
    clr(8'h00);
    pkt(1, 3);
    zlp(1);
    rd(1);
    chk("R6 partial read", nib(1), 4'b0001);
    rel(1);
    chk("R6 set at release", nib(1), 4'b0100);
    wipe();

    pkt(1, 2); pkt(1, 3);
    chk("R9 setup", nib(1), 4'b1001);
    rx_tok[1] = 1; clr_we = 1; clr_data = 8'h00; tick();
    chk("R9 nak wins", nib(1), 4'b0011);
    pkt(0, 1);
    rx_pkt[0] = 1; rx_len = 2; clr_we = 1; clr_data = 8'h00; tick();
    chk("R9 full wins", int'(status), 8'h19);
    wipe();

    for (int m = 0; m < 256; m++) begin
      rx_zlp = 2'b11; tick();
      rx_pkt = 2'b11; rx_len = 4; tick();
      rx_pkt = 2'b11; rx_len = 5; tick();
      rx_tok = 2'b11; tick();
      chk("R8 all set", int'(status), 8'hFF);
      clr(m);
      chk("R8 mask", int'(status), m | 8'h11);
      ep_en = 0; tick();
      chk("R11 disabled", int'(status), 0);
      ep_en = 2'b11;
    end

    cpu_ep = 0;
    pkt(0, 7);
    ep_en = 2'b10; tick();
    chk("R11 nibble", nib(0), 0);
    chk("R11 cnt", int'(cpu_cnt), 0);
    pkt(0, 5); zlp(0); tok(0);
    chk("R11 ignored", nib(0), 0);
    chk("R11 ignored cnt", int'(cpu_cnt), 0);
    ep_en = 2'b11; tick();
    chk("R11 enabled empty", nib(0), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule